// File: doc/BRIEF.md
# Index-Domain Modular Multiplier Tap

This block multiplies a data residue by a constant coefficient modulo a prime `m` without a multiplier array. Both operands reach it as discrete logarithms to a primitive radix `r` of `m`, called indices. Each operand also carries a flag that marks a zero value, because zero has no index. The product's index is the sum of the two indices modulo `m-1`. A dual-path adder forms this sum, and a combinational antilog table turns it back into a residue. The result is registered one cycle after the data strobe.

The coefficient is written once through a load strobe, already in index form with its zero flag, and it is held until the next load. Data arrives as a stream of index and zero-flag pairs qualified by a valid strobe. When either operand is flagged zero, the index sum is bypassed and the output is 0. Several such taps can share one data index stream, each holding its own coefficient. Summing the tap outputs and the final reduction are done outside this block.

Top module: `idx_mult_tap`

## Requirements
- R1: After reset, `prod_vld` and `prod_res` are 0 and the stored coefficient is marked zero, so data sent before any load yields 0.
- R2: For nonzero operands with indices `i` and `j` in [0, m-2], the output residue equals `r^((i+j) mod (m-1)) mod m`, which is the integer product of the two residues mod m; for example, m=5 with residues 3 and 4 gives 2.
- R3: A data word with `dat_zero` = 1 produces residue 0, whatever `dat_idx` holds.
- R4: A stored coefficient with its zero flag set produces residue 0 for every data word, whatever index bits were loaded with it.
- R5: The coefficient index and zero flag change only in a cycle where `coef_ld` = 1; in other cycles the values on the coefficient inputs are ignored.
- R6: When `coef_ld` and `dat_vld` are high in the same cycle, that data word is multiplied by the coefficient stored before the load, and the new coefficient applies from the next word on.
- R7: `prod_vld` is `dat_vld` delayed by one clock, and `prod_res` holds its value in cycles after `dat_vld` was 0.
- R8: `prod_res` is always below m.
- R9: An index sum of m-1 or more wraps to the sum minus (m-1); for example, m=13, r=2, residues 12 and 12 (index 6 each) give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_ld | input | 1 | Load strobe for the coefficient |
| coef_idx_in | input | $clog2(MOD-1) | Coefficient index, in [0, MOD-2] |
| coef_zero_in | input | 1 | Coefficient is zero |
| dat_vld | input | 1 | Data word valid |
| dat_idx | input | $clog2(MOD-1) | Data index, in [0, MOD-2] |
| dat_zero | input | 1 | Data value is zero |
| prod_vld | output | 1 | Product valid, one cycle after `dat_vld` |
| prod_res | output | $clog2(MOD) | Product residue in [0, MOD-1] |

## Verification
The bound checker watches the timing contract on every cycle. It checks the one-cycle valid delay and the holding of the result when no data is present. It also checks that the coefficient stays unchanged without a load, that the zero bypass forces 0 for either flag, and that the result stays in range. Whether a residue is the correct product can only be shown by the bench's scenarios. These cover an exhaustive sweep of every operand pair for the moduli 5, 13, 17, 29 and 41, a table of directed pairs that includes the index wrap, and the timing order of a load that coincides with data.

// File: rtl/idx_mult_pkg.sv
package idx_mult_pkg;

    // r^e mod m, evaluated at elaboration to build the antilog table
    function automatic int pow_mod(input int base, input int e, input int m);
        int acc;
        acc = 1 % m;
        for (int k = 0; k < e; k++) begin
            acc = (acc * base) % m;
        end
        return acc;
    endfunction

endpackage

// File: rtl/idx_mod_adder.sv
// Dual-path adder modulo MODV: a+b and a+b-MODV are formed side by side,
// and the sign of the second one picks the result.
module idx_mod_adder #(
    parameter int MODV = 12,
    localparam int W = $clog2(MODV)
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum_mod
);
    localparam logic [W+1:0] MODW = (W + 2)'(MODV);

    logic [W+1:0] raw_sum;
    logic [W+1:0] red_sum;
    logic         unused_hi;

    always_comb begin
        raw_sum = {2'b00, opa} + {2'b00, opb};
        red_sum = raw_sum - MODW;
        sum_mod = red_sum[W+1] ? raw_sum[W-1:0] : red_sum[W-1:0];
    end

    assign unused_hi = ^{raw_sum[W+1:W], red_sum[W]};
endmodule

// File: rtl/idx_antilog.sv
// Combinational antilog table: residue = RADIX^idx mod MOD, for MOD-1 entries.
module idx_antilog #(
    parameter int MOD   = 13,
    parameter int RADIX = 2,
    localparam int IW   = $clog2(MOD - 1),
    localparam int RW   = $clog2(MOD),
    localparam int NENT = MOD - 1
) (
    input  logic [IW-1:0] idx,
    output logic [RW-1:0] res
);
    logic [RW-1:0] tbl [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        assign tbl[e] = RW'(idx_mult_pkg::pow_mod(RADIX, e, MOD));
    end

    always_comb begin
        if ({1'b0, idx} < (IW + 1)'(NENT)) begin
            res = tbl[idx];
        end else begin
            res = '0;
        end
    end
endmodule

// File: rtl/idx_mult_tap.sv
module idx_mult_tap #(
    parameter int MOD   = 13,
    parameter int RADIX = 2,
    localparam int IW   = $clog2(MOD - 1),
    localparam int RW   = $clog2(MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_ld,
    input  logic [IW-1:0] coef_idx_in,
    input  logic          coef_zero_in,
    input  logic          dat_vld,
    input  logic [IW-1:0] dat_idx,
    input  logic          dat_zero,
    output logic          prod_vld,
    output logic [RW-1:0] prod_res
);
    typedef struct packed {
        logic [IW-1:0] coef_idx;
        logic          coef_zero;
        logic          out_vld;
        logic [RW-1:0] out_res;
    } tap_state_t;

    localparam tap_state_t RST_VAL = '{coef_idx: '0, coef_zero: 1'b1,
                                       out_vld: 1'b0, out_res: '0};

    tap_state_t st_d;
    tap_state_t st_q;
    logic [IW-1:0] idx_sum;
    logic [RW-1:0] alog_res;
    logic          coef_zero_cur;
    logic [IW-1:0] coef_idx_cur;

    idx_mod_adder #(.MODV(MOD - 1)) u_add (
        .opa     (dat_idx),
        .opb     (st_q.coef_idx),
        .sum_mod (idx_sum)
    );

    idx_antilog #(.MOD(MOD), .RADIX(RADIX)) u_alog (
        .idx (idx_sum),
        .res (alog_res)
    );

    always_comb begin
        st_d = st_q;
        if (coef_ld) begin
            st_d.coef_idx  = coef_idx_in;
            st_d.coef_zero = coef_zero_in;
        end
        st_d.out_vld = dat_vld;
        if (dat_vld) begin
            // zero has no index: bypass the sum
            st_d.out_res = (dat_zero || st_q.coef_zero) ? '0 : alog_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_vld      = st_q.out_vld;
    assign prod_res      = st_q.out_res;
    assign coef_zero_cur = st_q.coef_zero;
    assign coef_idx_cur  = st_q.coef_idx;
endmodule

// File: rtl/idx_mult_tap_chk.sv
module idx_mult_tap_chk #(
    parameter int MOD = 13,
    localparam int IW = $clog2(MOD - 1),
    localparam int RW = $clog2(MOD)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          coef_ld,
    input logic          dat_vld,
    input logic          dat_zero,
    input logic          coef_zero_cur,
    input logic [IW-1:0] coef_idx_cur,
    input logic          prod_vld,
    input logic [RW-1:0] prod_res
);
    a_r7_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dat_vld |=> prod_vld);

    a_r7_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_vld |=> !prod_vld);

    a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_vld |=> $stable(prod_res));

    a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_vld && dat_zero) |=> (prod_res == '0));

    a_r4_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_vld && coef_zero_cur) |=> (prod_res == '0));

    a_r5_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_ld |=> ($stable(coef_idx_cur) && $stable(coef_zero_cur)));

    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, prod_res} < (RW + 1)'(MOD));
endmodule

bind idx_mult_tap idx_mult_tap_chk #(.MOD(MOD)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .coef_ld       (coef_ld),
    .dat_vld       (dat_vld),
    .dat_zero      (dat_zero),
    .coef_zero_cur (coef_zero_cur),
    .coef_idx_cur  (coef_idx_cur),
    .prod_vld      (prod_vld),
    .prod_res      (prod_res)
);

// File: tb/idx_mult_tap_test.sv
module idx_mult_tap_test;
    localparam int M0 = 13;
    localparam int R0 = 2;
    localparam int IW0 = $clog2(M0 - 1);
    localparam int RW0 = $clog2(M0);
    localparam int NSW = 5;
    localparam int SW_MOD [NSW] = '{5, 13, 17, 29, 41};
    localparam int SW_RAD [NSW] = '{2, 2, 3, 2, 6};
    localparam int NVEC = 8;
    // {coef residue, data residue, expected product} for m = 13
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd3,  8'd4,  8'd12}, {8'd12, 8'd12, 8'd1},  {8'd7, 8'd2,  8'd1},
        {8'd0,  8'd5,  8'd0},  {8'd5,  8'd0,  8'd0},  {8'd1, 8'd1,  8'd1},
        {8'd6,  8'd11, 8'd1},  {8'd9,  8'd10, 8'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    bit go = 1'b0;

    function automatic int blog(input int a, input int m, input int r);
        int p;
        p = 1;
        for (int e = 0; e < m - 1; e++) begin
            if (p == a) return e;
            p = (p * r) % m;
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    logic           c_ld, c_zero, d_vld, d_zero, p_vld;
    logic [IW0-1:0] c_idx, d_idx;
    logic [RW0-1:0] p_res;

    idx_mult_tap #(.MOD(M0), .RADIX(R0)) uut (
        .clk(clk), .rst_n(rst_n), .coef_ld(c_ld), .coef_idx_in(c_idx),
        .coef_zero_in(c_zero), .dat_vld(d_vld), .dat_idx(d_idx),
        .dat_zero(d_zero), .prod_vld(p_vld), .prod_res(p_res)
    );

    task automatic put_coef(input int a);
        c_ld   = 1'b1;
        c_zero = (a == 0);
        c_idx  = IW0'(blog(a, M0, R0));
    endtask

    task automatic put_dat(input int a);
        d_vld  = 1'b1;
        d_zero = (a == 0);
        d_idx  = IW0'(blog(a, M0, R0));
    endtask

    // exhaustive sweeps, one instance per modulus (R2, R8)
    for (genvar g = 0; g < NSW; g++) begin : g_sw
        localparam int M = SW_MOD[g];
        localparam int R = SW_RAD[g];
        localparam int IW = $clog2(M - 1);
        localparam int RW = $clog2(M);
        logic          s_ld = 1'b0, s_cz = 1'b0, s_dv = 1'b0, s_dz = 1'b0, s_pv;
        logic [IW-1:0] s_ci = '0, s_di = '0;
        logic [RW-1:0] s_pr;

        idx_mult_tap #(.MOD(M), .RADIX(R)) u_sweep (
            .clk(clk), .rst_n(rst_n), .coef_ld(s_ld), .coef_idx_in(s_ci),
            .coef_zero_in(s_cz), .dat_vld(s_dv), .dat_idx(s_di),
            .dat_zero(s_dz), .prod_vld(s_pv), .prod_res(s_pr)
        );

        initial begin
            wait (go);
            for (int a = 0; a < M; a++) begin
                @(negedge clk);
                s_ld = 1'b1; s_cz = (a == 0); s_ci = IW'(blog(a, M, R));
                @(negedge clk);
                s_ld = 1'b0;
                for (int b = 0; b < M; b++) begin
                    s_dv = 1'b1; s_dz = (b == 0); s_di = IW'(blog(b, M, R));
                    @(negedge clk);
                    check(s_pv == 1'b1 && int'(s_pr) == (a * b) % M,
                          $sformatf("R2 sweep m=%0d %0d*%0d", M, a, b),
                          int'(s_pr), (a * b) % M);
                    check(int'(s_pr) < M, $sformatf("R8 range m=%0d", M), int'(s_pr), M - 1);
                end
                s_dv = 1'b0;
            end
            n_done++;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        c_ld = 1'b0; c_zero = 1'b0; c_idx = '0;
        d_vld = 1'b0; d_zero = 1'b0; d_idx = '0;
        repeat (3) @(negedge clk);
        check(p_vld == 1'b0, "R1 reset valid", int'(p_vld), 0);
        check(p_res == '0, "R1 reset result", int'(p_res), 0);
        rst_n = 1'b1;

        // R1: no coefficient loaded yet, product is zero
        @(negedge clk); put_dat(7);
        @(negedge clk); d_vld = 1'b0;
        check(p_res == '0, "R1 unloaded coef", int'(p_res), 0);

        // directed table, includes index wrap cases (R9)
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk); put_coef(int'(VEC[v][23:16]));
            @(negedge clk); c_ld = 1'b0; put_dat(int'(VEC[v][15:8]));
            @(negedge clk); d_vld = 1'b0;
            check(int'(p_res) == int'(VEC[v][7:0]), $sformatf("R2 R9 vector %0d", v),
                  int'(p_res), int'(VEC[v][7:0]));
        end

        // R6: load and data in the same cycle
        @(negedge clk); put_coef(3);
        @(negedge clk); put_coef(5); put_dat(4);
        @(negedge clk); c_ld = 1'b0;
        check(int'(p_res) == 12, "R6 old coef used", int'(p_res), 12);
        check(p_vld == 1'b1, "R7 valid after data", int'(p_vld), 1);
        put_dat(4);
        @(negedge clk); d_vld = 1'b0;
        check(int'(p_res) == 7, "R6 new coef next word", int'(p_res), 7);

        // R5: coefficient inputs ignored without load
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); c_idx = IW0'(k + 7); c_zero = 1'b1;
        end
        @(negedge clk); put_dat(2);
        @(negedge clk); d_vld = 1'b0;
        check(int'(p_res) == 10, "R5 coef held", int'(p_res), 10);

        // R7: idle cycle keeps result, drops valid
        @(negedge clk);
        check(p_vld == 1'b0, "R7 valid drops", int'(p_vld), 0);
        check(int'(p_res) == 10, "R7 result held", int'(p_res), 10);

        // R3: zero flag on data wins over index bits
        d_vld = 1'b1; d_zero = 1'b1; d_idx = IW0'(5);
        @(negedge clk); d_vld = 1'b0;
        check(p_res == '0, "R3 zero data", int'(p_res), 0);

        // R4: zero flag on coefficient wins over loaded index bits
        c_ld = 1'b1; c_zero = 1'b1; c_idx = IW0'(3);
        @(negedge clk); c_ld = 1'b0; put_dat(6);
        @(negedge clk); d_vld = 1'b0;
        check(p_res == '0, "R4 zero coef", int'(p_res), 0);

        go = 1'b1;
        wait (n_done == NSW);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule